// File: doc/BRIEF.md
# I2C DAC Write-Command Sequencer

This block forms and issues write transactions for a single-channel 12-bit digital-to-analog converter that sits on an I2C bus and keeps a copy of its setting in non-volatile memory. It accepts a 12-bit output code, a write mode, two power-down bits and the level of the converter's low address strap. From these it builds a fast-write frame, a register-write frame or a register-plus-EEPROM frame. It then hands the frame, one byte at a time, to a separate byte-level I2C master that generates START, STOP and the acknowledge bit.

After reset the sequencer waits for a programmable power-up interval. It then sends a start-up frame whose code and mode are parameters. After that, each update request produces one frame. Requests are not queued. A single holding register keeps the most recent code, mode and power-down values, and the sequencer sends them as soon as it is idle. If the master reports a missing acknowledge, the sequencer abandons the frame, asks for a STOP and reports an error.

Top module: `dac_write_seq`

## Requirements
- R1: The first byte of every frame is the slave address followed by the write bit. It is `{1100, 0, 0, A0, 0}`, which is 0xC0 or 0xC2. A0 is the strap level sampled in the cycle the frame is launched.
- R2: Modes 1 and 3 send command 010 and mode 2 sends command 011. In these modes the frame has four bytes: address, then `{C2 C1 C0, 0, 0, PD1, PD0, 0}`, then code bits 11..4, then `{code bits 3..0, 0000}`.
- R3: Mode 0 (fast write) sends a three-byte frame: address, then `{0, 0, PD1, PD0, code bits 11..8}`, then code bits 7..0.
- R4: `last_byte` is high only while the final byte of a frame is presented.
- R5: The first `start_req` after reset rises in clock cycle PWRUP_CYCLES+1 after reset is released, and never earlier. Its frame carries INIT_CODE, INIT_MODE and power-down 00. If an update request arrives during the wait, that request's values are sent in place of the start-up values.
- R6: `start_req` is a single-cycle pulse in the cycle `busy` rises. `byte_valid` then stays high with an unchanged `byte_data` until `byte_done`.
- R7: When `byte_done` comes with `ack_ok` low, no further byte of that frame is presented. `stop_req` stays high until the next `byte_done`, and `err` pulses for one cycle. No `done` is given for that frame.
- R8: `busy` stays high from `start_req` until the frame ends. `done` pulses for one cycle, with `busy` low, after each frame that completes without a NACK.
- R9: If several update requests arrive while a frame is in flight, exactly one further frame follows, and it carries the latest request's values.
- R10: An update request that lands in the same cycle as a frame launch does not alter the frame being launched. Its values go out in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_req | input | 1 | Update request strobe |
| upd_code | input | 12 | Output code to send |
| upd_mode | input | 2 | 0 fast, 1 register, 2 register+EEPROM, 3 register |
| upd_pd | input | 2 | Power-down bits PD1 PD0 |
| addr_a0 | input | 1 | Level of the converter's A0 strap |
| start_req | output | 1 | Asks the byte master for a START |
| byte_valid | output | 1 | A byte is presented |
| byte_data | output | 8 | Byte to transmit |
| last_byte | output | 1 | STOP follows this byte |
| stop_req | output | 1 | STOP-only request after a NACK |
| byte_done | input | 1 | Byte (or STOP-only request) finished |
| ack_ok | input | 1 | Slave acknowledged the byte just finished |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame completed cleanly |
| err | output | 1 | Frame aborted on NACK |

## Verification
The collision that matters is an update request that is latched in the same clock edge at which the idle sequencer launches the previously held values. The bench provokes it by holding `upd_req` high for two consecutive cycles with different codes. The first cycle fills the holding register, and the second lands exactly on the launch edge. It then judges by the byte log that two complete frames went out, first the earlier values and then the later ones, with two `start_req` and two `done` pulses. A related case, several requests during a busy frame, is judged by the log holding exactly one follow-on frame carrying the newest values.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
   localparam int CODE_W    = 12;
   localparam int FRAME_MAX = 4;
   localparam int IDX_W     = $clog2(FRAME_MAX);
   localparam int LEN_W     = IDX_W + 1;

   typedef enum logic [1:0] {
      MODE_FAST    = 2'd0,
      MODE_REG     = 2'd1,
      MODE_NVM     = 2'd2,
      MODE_REG_ALT = 2'd3
   } wr_mode_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      wr_mode_e          mode;
      logic [1:0]        pd;
   } dac_req_t;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_SEND = 2'd1,
      SQ_STOP = 2'd2
   } seq_state_e;

   function automatic logic [2:0] cmd_bits(input wr_mode_e m);
      return (m == MODE_NVM) ? 3'b011 : 3'b010;
   endfunction
endpackage

// File: rtl/dac_pwrup_timer.sv
module dac_pwrup_timer #(
   parameter int CYCLES = 1_000_000
) (
   input  logic clk,
   input  logic rst_n,
   output logic ready
);
   generate
      if (CYCLES == 0) begin : g_none
         assign ready = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CYCLES + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   cnt_q <= '0;
            else if (cnt_q != CW'(CYCLES)) cnt_q <= cnt_q + 1'b1;
         end
         assign ready = (cnt_q == CW'(CYCLES));
      end
   endgenerate
endmodule

// File: rtl/dac_req_hold.sv
module dac_req_hold
   import dac_seq_pkg::*;
#(
   parameter logic [CODE_W-1:0] INIT_CODE = 12'h400,
   parameter int                INIT_MODE = 1,
   parameter bit                INIT_SEND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_req,
   input  logic [CODE_W-1:0] upd_code,
   input  logic [1:0]        upd_mode,
   input  logic [1:0]        upd_pd,
   input  logic              take,
   output dac_req_t          pend,
   output logic              pend_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend.code  <= INIT_CODE;
         pend.mode  <= wr_mode_e'(INIT_MODE[1:0]);
         pend.pd    <= 2'b00;
         pend_valid <= INIT_SEND;
      end else if (upd_req) begin
         pend.code  <= upd_code;
         pend.mode  <= wr_mode_e'(upd_mode);
         pend.pd    <= upd_pd;
         pend_valid <= 1'b1;
      end else if (take) begin
         pend_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
   import dac_seq_pkg::*;
#(
   parameter logic [3:0] DEV_CODE = 4'b1100,
   parameter logic [1:0] HW_BITS  = 2'b00
) (
   input  dac_req_t         req,
   input  logic             a0,
   input  logic [IDX_W-1:0] idx,
   output logic [7:0]       byte_o,
   output logic             last_o,
   output logic [LEN_W-1:0] len_o
);
   logic [7:0] slot [FRAME_MAX];

   always_comb begin
      slot[0] = {DEV_CODE, HW_BITS, a0, 1'b0};
      if (req.mode == MODE_FAST) begin
         slot[1] = {2'b00, req.pd, req.code[11:8]};
         slot[2] = req.code[7:0];
         slot[3] = 8'h00;
         len_o   = LEN_W'(3);
      end else begin
         slot[1] = {cmd_bits(req.mode), 2'b00, req.pd, 1'b0};
         slot[2] = req.code[11:4];
         slot[3] = {req.code[3:0], 4'b0000};
         len_o   = LEN_W'(4);
      end
   end

   assign byte_o = slot[idx];
   assign last_o = ({1'b0, idx} == (len_o - 1'b1));
endmodule

// File: rtl/dac_write_seq.sv
module dac_write_seq
   import dac_seq_pkg::*;
#(
   parameter int                PWRUP_CYCLES = 1_000_000,
   parameter logic [CODE_W-1:0] INIT_CODE    = 12'h400,
   parameter int                INIT_MODE    = 1,
   parameter bit                INIT_SEND    = 1'b1,
   parameter logic [3:0]        DEV_CODE     = 4'b1100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_req,
   input  logic [CODE_W-1:0] upd_code,
   input  logic [1:0]        upd_mode,
   input  logic [1:0]        upd_pd,
   input  logic              addr_a0,
   output logic              start_req,
   output logic              byte_valid,
   output logic [7:0]        byte_data,
   output logic              last_byte,
   output logic              stop_req,
   input  logic              byte_done,
   input  logic              ack_ok,
   output logic              busy,
   output logic              done,
   output logic              err
);
   generate
      if (PWRUP_CYCLES < 0) begin : g_bad_wait
         $error("PWRUP_CYCLES must not be negative");
      end
      if (INIT_MODE < 0 || INIT_MODE > 3) begin : g_bad_mode
         $error("INIT_MODE must be 0..3");
      end
   endgenerate

   seq_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   dac_req_t         cur_q;
   logic             a0_q;
   logic             start_q, done_q, err_q;
   logic             pwr_ready, pend_valid, launch;
   dac_req_t         pend;
   logic [LEN_W-1:0] frame_len;
   logic             is_last;

   dac_pwrup_timer #(.CYCLES(PWRUP_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .ready(pwr_ready)
   );

   assign launch = (state_q == SQ_IDLE) && pwr_ready && pend_valid;

   dac_req_hold #(.INIT_CODE(INIT_CODE), .INIT_MODE(INIT_MODE), .INIT_SEND(INIT_SEND)) u_hold (
      .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_code(upd_code),
      .upd_mode(upd_mode), .upd_pd(upd_pd), .take(launch),
      .pend(pend), .pend_valid(pend_valid)
   );

   dac_frame_pack #(.DEV_CODE(DEV_CODE)) u_pack (
      .req(cur_q), .a0(a0_q), .idx(idx_q),
      .byte_o(byte_data), .last_o(is_last), .len_o(frame_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
         a0_q    <= 1'b0;
         start_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         case (state_q)
            SQ_IDLE: if (launch) begin
               state_q <= SQ_SEND;
               start_q <= 1'b1;
               idx_q   <= '0;
               cur_q   <= pend;
               a0_q    <= addr_a0;
            end
            SQ_SEND: if (byte_done) begin
               if (!ack_ok) begin
                  state_q <= SQ_STOP;
                  err_q   <= 1'b1;
               end else if (is_last) begin
                  state_q <= SQ_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            SQ_STOP: if (byte_done) state_q <= SQ_IDLE;
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign start_req  = start_q;
   assign byte_valid = (state_q == SQ_SEND);
   assign last_byte  = byte_valid && is_last;
   assign stop_req   = (state_q == SQ_STOP);
   assign busy       = (state_q != SQ_IDLE);
   assign done       = done_q;
   assign err        = err_q;

   a_r5_no_early_start: assert property (@(posedge clk) disable iff (!rst_n)
      start_req |-> pwr_ready);
   a_r6_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> start_req);
   a_r6_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_done) |=> (byte_valid && $stable(byte_data)));
   a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid |-> ({1'b0, idx_q} < frame_len));
   a_r7_no_byte_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_done && !ack_ok) |=> (!byte_valid && stop_req));
   a_r7_err_stop: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (stop_req && !done));
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: tb/test_dac_write_seq.sv
module test_dac_write_seq;
   localparam int PWR = 25;

   logic clk = 1'b0, rst_n = 1'b0;
   logic upd_req = 1'b0, addr_a0 = 1'b0, byte_done = 1'b0, ack_ok = 1'b1;
   logic [11:0] upd_code = '0;
   logic [1:0]  upd_mode = '0, upd_pd = '0;
   logic start_req, byte_valid, last_byte, stop_req, busy, done, err;
   logic [7:0] byte_data;

   int errors = 0, checks = 0;
   int log_b [64];
   int log_l [64];
   int nlog = 0, nack_at = 99;
   int n_done = 0, n_err = 0, n_start = 0, n_stop = 0;

   always #4 clk = ~clk;

   dac_write_seq #(.PWRUP_CYCLES(PWR)) i_dac_write_seq (
      .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .upd_code(upd_code),
      .upd_mode(upd_mode), .upd_pd(upd_pd), .addr_a0(addr_a0),
      .start_req(start_req), .byte_valid(byte_valid), .byte_data(byte_data),
      .last_byte(last_byte), .stop_req(stop_req), .byte_done(byte_done),
      .ack_ok(ack_ok), .busy(busy), .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input int mode);
      return (mode == 0) ? 3 : 4;
   endfunction

   function automatic int exp_byte(input int code, input int mode, input int pd,
                                   input int a0, input int i);
      if (i == 0) return 192 + a0 * 2;
      if (mode == 0) begin
         if (i == 1) return pd * 16 + code / 256;
         return code % 256;
      end
      if (i == 1) return ((mode == 2) ? 3 : 2) * 32 + pd * 2;
      if (i == 2) return code / 16;
      return (code % 16) * 16;
   endfunction

   task automatic responder();
      bit gap = 1'b0;
      forever begin
         @(negedge clk);
         byte_done = 1'b0;
         ack_ok    = 1'b1;
         if (gap) gap = 1'b0;
         else if (stop_req) begin
            byte_done = 1'b1; n_stop++; gap = 1'b1;
         end else if (byte_valid) begin
            if (nlog < 64) begin
               log_b[nlog] = byte_data;
               log_l[nlog] = last_byte;
            end
            ack_ok    = (nlog != nack_at);
            byte_done = 1'b1;
            nlog++;
            gap = 1'b1;
         end
      end
   endtask

   task automatic monitor();
      forever begin
         @(negedge clk);
         if (done)      n_done++;
         if (err)       n_err++;
         if (start_req) n_start++;
      end
   endtask

   task automatic req(input int code, input int mode, input int pd, input int a0);
      @(negedge clk);
      upd_code = 12'(code); upd_mode = 2'(mode); upd_pd = 2'(pd);
      addr_a0  = a0[0]; upd_req = 1'b1;
      @(negedge clk);
      upd_req = 1'b0;
   endtask

   task automatic check_frame(input int base, input int code, input int mode,
                              input int pd, input int a0, input string tag);
      int len = exp_len(mode);
      for (int i = 0; i < len; i++) begin
         chk(log_b[base+i] == exp_byte(code, mode, pd, a0, i), tag,
             log_b[base+i], exp_byte(code, mode, pd, a0, i));
         chk(log_l[base+i] == ((i == len-1) ? 1 : 0), "R4 last_byte flag",
             log_l[base+i], (i == len-1) ? 1 : 0);
      end
   endtask

   task automatic reset_checks();
      chk(!busy && !byte_valid && !start_req, "R8 reset idle", {busy, byte_valid, start_req}, 0);
      chk(!stop_req && !done && !err, "R7 reset no stop/err", {stop_req, done, err}, 0);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(8 * 190000);
      errors++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      int c, s0, d0, e0, p0;
      fork
         responder();
         monitor();
      join_none
      repeat (3) @(negedge clk);
      reset_checks();
      rst_n = 1'b1;
      // R5: power-up wait, then start-up frame
      c = 0;
      while (!start_req && c < PWR + 10) begin
         @(posedge clk); c++;
         @(negedge clk);
         if (c < PWR + 1) chk(!byte_valid, "R5 no byte during wait", byte_valid, 0);
      end
      chk(c == PWR + 1, "R5 first start cycle", c, PWR + 1);
      chk(busy, "R6 busy with start", busy, 1);
      repeat (20) @(negedge clk);
      chk(nlog == 4, "R5 init frame length", nlog, 4);
      check_frame(0, 12'h400, 1, 0, 0, "R5 init frame byte");
      chk(n_done == 1, "R8 init done", n_done, 1);

      // R1 R2 R3 R4 R8: sweep of modes, power-down, strap and codes
      for (int a0 = 0; a0 < 2; a0++)
         for (int m = 0; m < 4; m++)
            for (int pd = 0; pd < 4; pd++)
               for (int k = 0; k < 4; k++) begin
                  int code = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h5A3 : 12'h81C;
                  nlog = 0; s0 = n_start; d0 = n_done;
                  req(code, m, pd, a0);
                  repeat (14) @(negedge clk);
                  chk(nlog == exp_len(m), (m == 0) ? "R3 frame length" : "R2 frame length",
                      nlog, exp_len(m));
                  check_frame(0, code, m, pd, a0, (m == 0) ? "R3/R1 byte" : "R2/R1 byte");
                  chk(n_start - s0 == 1, "R6 one start pulse", n_start - s0, 1);
                  chk(n_done - d0 == 1 && !busy, "R8 one done, idle", n_done - d0, 1);
               end

      // R7: NACK at each byte position
      for (int pos = 0; pos < 4; pos++) begin
         nlog = 0; nack_at = pos; d0 = n_done; e0 = n_err; p0 = n_stop;
         req(12'h3C5, 2, 0, 0);
         repeat (16) @(negedge clk);
         chk(nlog == pos + 1, "R7 bytes before abort", nlog, pos + 1);
         chk(n_err - e0 == 1, "R7 one err pulse", n_err - e0, 1);
         chk(n_stop - p0 == 1, "R7 one stop request", n_stop - p0, 1);
         chk(n_done == d0 && !busy, "R7 no done, idle", n_done - d0, 0);
         nack_at = 99;
      end

      // R9: several requests while busy, latest one wins
      nlog = 0; s0 = n_start;
      req(12'h111, 1, 0, 0);
      @(negedge clk);
      chk(busy, "R9 frame in flight", busy, 1);
      req(12'h222, 1, 1, 0);
      req(12'h333, 2, 2, 0);
      repeat (30) @(negedge clk);
      chk(nlog == 8, "R9 two frames only", nlog, 8);
      check_frame(0, 12'h111, 1, 0, 0, "R9 first frame");
      check_frame(4, 12'h333, 2, 2, 0, "R9 latest values");
      chk(n_start - s0 == 2, "R9 start count", n_start - s0, 2);

      // R10: request lands on the launch edge
      nlog = 0; s0 = n_start; d0 = n_done;
      @(negedge clk);
      upd_code = 12'hABC; upd_mode = 2'd1; upd_pd = 2'd0; upd_req = 1'b1;
      @(negedge clk);
      upd_code = 12'h0F7; upd_mode = 2'd0; upd_pd = 2'd3;
      @(negedge clk);
      upd_req = 1'b0;
      repeat (30) @(negedge clk);
      chk(nlog == 7, "R10 both frames sent", nlog, 7);
      check_frame(0, 12'hABC, 1, 0, 0, "R10 launched values");
      check_frame(4, 12'h0F7, 0, 3, 0, "R10 later values");
      chk(n_done - d0 == 2 && n_start - s0 == 2, "R10 two completions", n_done - d0, 2);

      // R5: a request during the wait replaces the start-up values
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      reset_checks();
      nlog = 0;
      rst_n = 1'b1;
      req(12'h9E1, 0, 1, 1);
      repeat (PWR + 20) @(negedge clk);
      chk(nlog == 3, "R5 replaced frame length", nlog, 3);
      check_frame(0, 12'h9E1, 0, 1, 1, "R5 replaced frame byte");

      summary();
   end
endmodule